// File: doc/BRIEF.md
# Heartbeat Pattern Display Sequencer

This block animates a four-digit seven-segment display with a repeating four-step "heartbeat". Each step lights a few vertical segments, so the picture appears to pulse in from the middle of the display and back out again. Every flip-flop runs on the one system clock. The beat rate comes from a counter that issues a one-cycle enable pulse. The block never makes a divided clock.

A single `fast` input picks the rate at run time. When `fast` is low, each step is held for `SLOW_TICKS` clock cycles. The default is 2,500,000 cycles, which is 50 ms at 50 MHz and gives a 5 Hz beat. When `fast` is high, each step is held for `FAST_TICKS` cycles. The default is 1,250,000 cycles, which is 25 ms and gives a 10 Hz beat. A synchronous reset returns the animation to its first step and restarts the interval.

Top module: `heartbeat_seq`

## Requirements
- R1: The segment outputs change only on the clock edge that ends an interval. They hold steady on every other cycle, including cycles where `fast` toggles.
- R2: While `rst` is high at a rising edge, the interval count returns to zero and the display shows step 0. After `rst` falls, step 0 is held for one full interval.
- R3: The steps follow the order 0, 1, 2, 3 and then repeat. Step 0 lights the inner vertical pair of the two middle digits. Steps 1 and 3 light the outer vertical pair of the two middle digits. Step 2 lights the outer vertical segments of the two end digits.
- R4: With `fast` low, each step is held for exactly `SLOW_TICKS` cycles.
- R5: With `fast` high, each step is held for exactly `FAST_TICKS` cycles.
- R6: Suppose `fast` rises while the count already exceeds `FAST_TICKS-1`. The count then restarts from zero on the next edge, and the step is held for the cycles already spent, plus `FAST_TICKS`, plus 1.
- R7: Suppose `fast` changes while the count is still below the new limit. The current step then ends when the count reaches the new limit. Its total hold equals the new interval.
- R8: The segment outputs are active-low, with bit 0 = a, bit 1 = b, bit 2 = c, bit 3 = d, bit 4 = e, bit 5 = f and bit 6 = g.
  - A digit's right pair is b and c, which gives the code 7'b1111001.
  - A digit's left pair is e and f, which gives the code 7'b1001111.
  - An unlit digit reads 7'b1111111.
  - Digit 3 is the leftmost digit. On the middle digits, the inner pair is the right pair of digit 2 and the left pair of digit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that clocks every register |
| rst | input | 1 | Synchronous reset, active high |
| fast | input | 1 | High selects the short interval, low selects the long one |
| seg_d3 | output | 7 | Active-low segments of the leftmost digit |
| seg_d2 | output | 7 | Active-low segments of the left-middle digit |
| seg_d1 | output | 7 | Active-low segments of the right-middle digit |
| seg_d0 | output | 7 | Active-low segments of the rightmost digit |

## Verification
The hold-length bound assumes that `fast` changes at most once between two beats. Repeated toggling could restart the count over and over, so the bound would no longer hold. The minimum-hold check assumes `SLOW_TICKS` is at least `FAST_TICKS`. The bench uses 8 and 4 and toggles `fast` only at chosen counts, once per step. It always sets `fast` at a falling edge, so the design never sees a change at a sampling edge.

// File: rtl/heartbeat_seq.sv
module heartbeat_seq #(
  parameter int SLOW_TICKS = 2500000,
  parameter int FAST_TICKS = 1250000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       fast,
  output logic [6:0] seg_d3,
  output logic [6:0] seg_d2,
  output logic [6:0] seg_d1,
  output logic [6:0] seg_d0
);
  localparam int CW = $clog2(SLOW_TICKS + 1);
  localparam logic [CW-1:0] SLOW_LAST = CW'(SLOW_TICKS - 1);
  localparam logic [CW-1:0] FAST_LAST = CW'(FAST_TICKS - 1);
  localparam logic [6:0] DARK  = 7'b1111111;
  localparam logic [6:0] RIGHT = 7'b1111001;
  localparam logic [6:0] LEFT  = 7'b1001111;

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;
  logic [1:0]    phase;
  logic          tick;

  assign last = fast ? FAST_LAST : SLOW_LAST;
  assign tick = (cnt == last);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      phase <= 2'd0;
    end else begin
      if (cnt >= last) cnt <= '0;
      else             cnt <= cnt + 1'b1;
      if (tick) phase <= phase + 2'd1;
    end
  end

  always_comb begin
    case (phase)
      2'd0:    {seg_d3, seg_d2, seg_d1, seg_d0} = {DARK, RIGHT, LEFT, DARK};
      2'd2:    {seg_d3, seg_d2, seg_d1, seg_d0} = {LEFT, DARK, DARK, RIGHT};
      default: {seg_d3, seg_d2, seg_d1, seg_d0} = {DARK, LEFT, RIGHT, DARK};
    endcase
  end
endmodule

// File: rtl/heartbeat_seq_chk.sv
module heartbeat_seq_chk #(
  parameter int SLOW_TICKS = 2500000,
  parameter int FAST_TICKS = 1250000
) (
  input logic       clk,
  input logic       rst,
  input logic       tick,
  input logic [1:0] phase,
  input logic [6:0] seg_d3,
  input logic [6:0] seg_d2,
  input logic [6:0] seg_d1,
  input logic [6:0] seg_d0
);
  localparam int GW = $clog2(SLOW_TICKS + FAST_TICKS + 2) + 1;
  localparam logic [27:0] P0 = {7'h7F, 7'b1111001, 7'b1001111, 7'h7F};
  localparam logic [27:0] P1 = {7'h7F, 7'b1001111, 7'b1111001, 7'h7F};
  localparam logic [27:0] P2 = {7'b1001111, 7'h7F, 7'h7F, 7'b1111001};

  logic [27:0]   segs;
  logic [GW-1:0] gap;
  assign segs = {seg_d3, seg_d2, seg_d1, seg_d0};

  always_ff @(posedge clk) begin
    if (rst || tick) gap <= '0;
    else             gap <= gap + 1'b1;
  end

  a_r2_reset_step0: assert property (@(posedge clk) rst |=> segs == P0);
  a_r1_steady_without_tick: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(segs));
  a_r3_step_advance: assert property (@(posedge clk) disable iff (rst)
    tick |=> phase == $past(phase) + 2'd1);
  a_r3_legal_successor: assert property (@(posedge clk) disable iff (rst)
    ($past(segs) == P1 && segs != $past(segs) && !$past(rst)) |-> (segs == P0 || segs == P2));
  a_r5_min_hold: assert property (@(posedge clk) disable iff (rst)
    tick |-> int'(gap) >= FAST_TICKS - 1);
  a_r6_max_hold: assert property (@(posedge clk) disable iff (rst)
    int'(gap) <= SLOW_TICKS + FAST_TICKS);
endmodule

bind heartbeat_seq heartbeat_seq_chk #(.SLOW_TICKS(SLOW_TICKS), .FAST_TICKS(FAST_TICKS)) i_chk (
  .clk(clk), .rst(rst), .tick(tick), .phase(phase),
  .seg_d3(seg_d3), .seg_d2(seg_d2), .seg_d1(seg_d1), .seg_d0(seg_d0));

// File: tb/test_heartbeat_seq.sv
`timescale 1ns/1ps
module test_heartbeat_seq;
  localparam int SLOW = 8;
  localparam int FAST = 4;

  logic clk = 1'b0, rst = 1'b1, fast = 1'b0;
  logic [6:0] seg_d3, seg_d2, seg_d1, seg_d0;
  int n_chk = 0, n_fail = 0, ph = 0;
  bit done = 1'b0;

  heartbeat_seq #(.SLOW_TICKS(SLOW), .FAST_TICKS(FAST)) i_heartbeat_seq (
    .clk(clk), .rst(rst), .fast(fast),
    .seg_d3(seg_d3), .seg_d2(seg_d2), .seg_d1(seg_d1), .seg_d0(seg_d0));

  always #5 clk = ~clk;

  function automatic logic [6:0] lit(input bit left, input bit right);
    int m = 0;
    if (right) m = m | (1 << 1) | (1 << 2);
    if (left)  m = m | (1 << 4) | (1 << 5);
    return 7'(~m & 8'h7F);
  endfunction

  function automatic logic [27:0] expect_pat(input int p);
    case (p % 4)
      0:       return {lit(0,0), lit(0,1), lit(1,0), lit(0,0)};
      2:       return {lit(1,0), lit(0,0), lit(0,0), lit(0,1)};
      default: return {lit(0,0), lit(1,0), lit(0,1), lit(0,0)};
    endcase
  endfunction

  function automatic logic [27:0] segs();
    return {seg_d3, seg_d2, seg_d1, seg_d0};
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic measure(output int n);
    logic [27:0] prev = segs();
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (segs() == prev && n < 64);
  endtask

  task automatic hold_and_step(input int exp_hold, input string req);
    int n;
    measure(n);
    ph++;
    check(n == exp_hold, req, n, exp_hold);
    check(segs() == expect_pat(ph), "R3 order", segs(), expect_pat(ph));
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check(segs() == expect_pat(0), "R2 reset shows step 0", segs(), expect_pat(0));
    check(segs() == {7'h7F, 7'b1111001, 7'b1001111, 7'h7F}, "R8 step 0 code",
          segs(), {7'h7F, 7'b1111001, 7'b1001111, 7'h7F});
    rst = 1'b0;
    for (int i = 0; i < SLOW - 1; i++) begin
      @(negedge clk);
      check(segs() == expect_pat(0), "R1 steady between beats", segs(), expect_pat(0));
    end
    @(negedge clk);
    ph = 1;
    check(segs() == expect_pat(1), "R4 first beat ends after SLOW", segs(), expect_pat(1));
    check(segs() == {7'h7F, 7'b1001111, 7'b1111001, 7'h7F}, "R8 step 1 code",
          segs(), {7'h7F, 7'b1001111, 7'b1111001, 7'h7F});
    for (int k = 0; k < 11; k++) hold_and_step(SLOW, "R4 slow hold");
    check(segs() == expect_pat(0), "R3 three beats return to step 0", segs(), expect_pat(0));
    fast = 1'b1;
    for (int k = 0; k < 8; k++) hold_and_step(FAST, "R5 fast hold");
    // R7: fast to slow at count 2
    repeat (2) @(negedge clk);
    fast = 1'b0;
    fast = fast;
    hold_and_step(SLOW - 2, "R7 fast-to-slow remainder");
    // R7: slow to fast at count 2, still below the new limit
    repeat (2) @(negedge clk);
    fast = 1'b1;
    hold_and_step(FAST - 2, "R7 slow-to-fast remainder");
    fast = 1'b0;
    hold_and_step(SLOW, "R4 slow hold after switch");
    // R6: slow to fast at count 6, past the new limit
    repeat (6) @(negedge clk);
    check(segs() == expect_pat(ph), "R1 toggle does not move display", segs(), expect_pat(ph));
    fast = 1'b1;
    @(negedge clk);
    check(segs() == expect_pat(ph), "R1 no beat on restart", segs(), expect_pat(ph));
    measure(n);
    ph++;
    check(n + 7 == 6 + FAST + 1, "R6 restart hold", n + 7, 6 + FAST + 1);
    check(segs() == expect_pat(ph), "R3 order after restart", segs(), expect_pat(ph));
    // R2: reset mid-step
    repeat (3) @(negedge clk);
    rst = 1'b1;
    fast = 1'b0;
    @(negedge clk);
    check(segs() == expect_pat(0), "R2 mid-run reset", segs(), expect_pat(0));
    rst = 1'b0;
    ph = 0;
    hold_and_step(SLOW, "R2 full hold after reset");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule